// File: doc/BRIEF.md
# Synchronous Burst Read Clock and Latency Controller

This block runs synchronous burst reads from an external NOR flash or pseudo-static RAM. It builds the memory clock by dividing the system clock by a programmable ratio, and starts each burst by pulling chip select and the active-low address-valid strobe low with the start address. It then issues a programmable number of latency clocks, and after those it samples one data word on each rising memory clock edge until the programmed burst length has been read. The memory's active-low wait input holds off sampling on any data edge. When the burst ends, the clock parks low, chip select releases, and a programmable bus turnaround gap runs before the next request can be accepted.

Requests enter on a valid/ready channel. `req_ready` is high only while the controller is idle. A requester holds `req_valid` and `req_addr` steady until the handshake completes. Read data leaves as a valid-only stream with no back-pressure, because a burst in flight cannot be paused from the host side. The consumer must take each word in the cycle `rd_valid` is high. The configuration inputs are sampled at acceptance and must not change while a burst is running.

Top module: `sbm_burst_rd`

## Requirements
- R1: With ratio field `cfg_div_m1` = v, the memory clock period is D = v+1 system cycles, and a field of 0 behaves as 1 (D = 2). Each period is low for ceil(D/2) cycles and then high for floor(D/2) cycles.
- R2: The request is accepted on the clock edge where `req_valid` and `req_ready` are both high. From that edge, `mem_ce_n` and `mem_adv_n` are low and `mem_adv_n` stays low for exactly D cycles. The first memory clock rise follows after ceil(D/2) cycles, and `mem_addr` holds the request address for the whole burst.
- R3: With latency field `cfg_lat` = f, the burst has L = f+2 latency edges. Rising edges are numbered from 0, and the edge that samples the address is edge 0. The first data word is sampled at rising edge L, unless wait is active on that edge.
- R4: With length field `cfg_len_m1` = n, exactly n+1 words are read. Each word is sampled from `mem_dq` at a rising edge, and `rd_valid` is high for one cycle, the cycle in which `mem_clk` has just risen, with that word on `rd_data`. `rd_valid` is low in all other cycles.
- R5: A rising edge from edge L onward is a data edge. On a data edge where `mem_wait_n` is low, no word is sampled and the clock keeps running. `mem_wait_n` has no effect on latency edges.
- R6: After the rising edge that samples the last word, the memory clock completes its period. Chip select then rises and `mem_clk` returns low in the same cycle, (k+1)*D cycles after acceptance, where k is the index of that last edge. No further rising edges occur.
- R7: With turnaround field `cfg_turn` = T, `req_ready` rises T cycles after `mem_ce_n` rises. When T = 0, `req_ready` rises in the same cycle.
- R8: After reset and while idle, `mem_clk` is low, `mem_ce_n` and `mem_adv_n` are high, `rd_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div_m1 | input | DIV_W | Clock divide ratio minus one (0 acts as 1) |
| cfg_lat | input | LAT_W | Latency clocks minus two |
| cfg_len_m1 | input | LEN_W | Burst length in words minus one |
| cfg_turn | input | TURN_W | Turnaround gap in system cycles |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | ADDR_W | Burst start address |
| mem_clk | output | 1 | Memory clock, low when idle |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_wait_n | input | 1 | Memory wait, active low |
| mem_dq | input | DATA_W | Read data from the memory |
| rd_valid | output | 1 | Word sampled this cycle |
| rd_data | output | DATA_W | Sampled word |

## Verification
Some properties are checked by assertions on every cycle. The clock and the address strobe only toggle while chip select is low, and a word is only delivered on a fresh clock rise with wait inactive. The address holds steady across the burst, and the clock parks low when chip select releases. The bench has to show the properties that depend on counts: the exact period and duty split for every ratio, the latency edge at which the first word appears, the words skipped under wait patterns, the cycle at which the burst ends and the length of the turnaround gap. It sweeps all divide ratios against several latencies, lengths and wait masks, and derives each expected value arithmetically.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_TURN  = 2'd2
  } sbm_state_e;

  // Latency field encodes clocks minus this bias.
  localparam int unsigned LAT_BIAS = 2;

endpackage

// File: rtl/sbm_clkgen.sv
module sbm_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             mem_clk,
  output logic             rise_now,
  output logic             end_now
);

  logic [DIV_W-1:0] ph_q;
  logic [DIV_W-1:0] last_ph;
  logic [DIV_W-1:0] lo_last;

  // A ratio field of zero is raised to one so that the clock keeps both phases.
  always_comb begin
    last_ph = (div_m1 == '0) ? DIV_W'(1) : div_m1;
    // The low phase is ceil(D/2) cycles, so it ends at floor((D-1)/2).
    lo_last = last_ph >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      mem_clk <= 1'b0;
    end else if (!run) begin
      ph_q    <= '0;
      mem_clk <= 1'b0;
    end else if (ph_q == last_ph) begin
      ph_q    <= '0;
      mem_clk <= 1'b0;
    end else begin
      ph_q <= ph_q + DIV_W'(1);
      if (ph_q == lo_last) mem_clk <= 1'b1;
    end
  end

  // The edge that raises mem_clk, and the edge that closes the period.
  assign rise_now = run && (ph_q == lo_last);
  assign end_now  = run && (ph_q == last_ph);

endmodule

// File: rtl/sbm_seq.sv
module sbm_seq
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DIV_W  = 4,
  parameter int LAT_W  = 4,
  parameter int LEN_W  = 4,
  parameter int TURN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DIV_W-1:0]  cfg_div_m1,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [TURN_W-1:0] cfg_turn,
  input  logic              rise_now,
  input  logic              end_now,
  input  logic              mem_wait_n,
  output logic              req_ready,
  output logic              run,
  output logic [DIV_W-1:0]  div_q,
  output logic              mem_ce_n,
  output logic              mem_adv_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cap_now
);

  localparam int LATC_W = LAT_W + 1;
  localparam int WCNT_W = LEN_W + 1;

  sbm_state_e        state_q;
  logic [LATC_W-1:0] lat_left_q;
  logic [WCNT_W-1:0] words_left_q;
  logic [TURN_W-1:0] turn_q;
  logic [TURN_W-1:0] tcnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic              data_edge;
  logic              burst_done;

  assign req_ready  = (state_q == ST_IDLE);
  assign run        = (state_q == ST_BURST);
  assign accept     = req_valid && req_ready;
  assign burst_done = (words_left_q == '0);
  // Once the latency edges are used up, every rise is a data edge until the count is spent.
  assign data_edge  = rise_now && (lat_left_q == '0) && !burst_done;
  assign cap_now    = data_edge && mem_wait_n;
  assign mem_addr   = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      lat_left_q   <= '0;
      words_left_q <= '0;
      turn_q       <= '0;
      tcnt_q       <= '0;
      addr_q       <= '0;
      div_q        <= '0;
      mem_ce_n     <= 1'b1;
      mem_adv_n    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q      <= ST_BURST;
            addr_q       <= req_addr;
            div_q        <= cfg_div_m1;
            lat_left_q   <= {1'b0, cfg_lat} + LATC_W'(LAT_BIAS);
            words_left_q <= {1'b0, cfg_len_m1} + WCNT_W'(1);
            turn_q       <= cfg_turn;
            mem_ce_n     <= 1'b0;
            mem_adv_n    <= 1'b0;
          end
        end
        ST_BURST: begin
          if (rise_now && (lat_left_q != '0)) lat_left_q <= lat_left_q - LATC_W'(1);
          if (cap_now) words_left_q <= words_left_q - WCNT_W'(1);
          if (end_now) mem_adv_n <= 1'b1;
          if (end_now && burst_done) begin
            mem_ce_n <= 1'b1;
            if (turn_q == '0) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_TURN;
              tcnt_q  <= turn_q - TURN_W'(1);
            end
          end
        end
        ST_TURN: begin
          if (tcnt_q == '0) state_q <= ST_IDLE;
          else              tcnt_q  <= tcnt_q - TURN_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbm_capture.sv
module sbm_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_now,
  input  logic [DATA_W-1:0] mem_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_now;
      if (cap_now) rd_data <= mem_dq;
    end
  end

endmodule

// File: rtl/sbm_burst_rd.sv
module sbm_burst_rd #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4,
  parameter int LAT_W  = 4,
  parameter int LEN_W  = 4,
  parameter int TURN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div_m1,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [TURN_W-1:0] cfg_turn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_clk,
  output logic              mem_ce_n,
  output logic              mem_adv_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wait_n,
  input  logic [DATA_W-1:0] mem_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic             run;
  logic             rise_now;
  logic             end_now;
  logic             cap_now;
  logic [DIV_W-1:0] div_q;

  sbm_seq #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .LAT_W(LAT_W), .LEN_W(LEN_W), .TURN_W(TURN_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .cfg_div_m1 (cfg_div_m1),
    .cfg_lat    (cfg_lat),
    .cfg_len_m1 (cfg_len_m1),
    .cfg_turn   (cfg_turn),
    .rise_now   (rise_now),
    .end_now    (end_now),
    .mem_wait_n (mem_wait_n),
    .req_ready  (req_ready),
    .run        (run),
    .div_q      (div_q),
    .mem_ce_n   (mem_ce_n),
    .mem_adv_n  (mem_adv_n),
    .mem_addr   (mem_addr),
    .cap_now    (cap_now)
  );

  sbm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .div_m1   (div_q),
    .mem_clk  (mem_clk),
    .rise_now (rise_now),
    .end_now  (end_now)
  );

  sbm_capture #(.DATA_W(DATA_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_now  (cap_now),
    .mem_dq   (mem_dq),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/sbm_burst_rd_chk.sv
module sbm_burst_rd_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_clk,
  input logic              mem_ce_n,
  input logic              mem_adv_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wait_n,
  input logic              rd_valid
);

  // R6 / R8: the clock toggles only inside a selected burst
  p_clk_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clk |-> !mem_ce_n);

  // R2: the address strobe is only low while chip select is low
  p_adv_in_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_ce_n);

  // R8: ready only with the bus parked
  p_ready_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_clk));

  // R4: a word is delivered only on a fresh clock rise
  p_valid_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(mem_clk));

  // R5: no word is taken while wait was active at the sampling edge
  p_wait_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_wait_n));

  // R2: a burst opens with the strobe low and the clock low
  p_start_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (!mem_adv_n && !mem_clk));

  // R2: address steady across the burst
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R2: the strobe releases mid-burst at a period boundary
  p_adv_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_adv_n) |-> (!mem_ce_n && !mem_clk));

  // R6: the clock is parked low when chip select releases
  p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> !mem_clk);

endmodule

bind sbm_burst_rd sbm_burst_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .mem_clk    (mem_clk),
  .mem_ce_n   (mem_ce_n),
  .mem_adv_n  (mem_adv_n),
  .mem_addr   (mem_addr),
  .mem_wait_n (mem_wait_n),
  .rd_valid   (rd_valid)
);

// File: tb/sbm_burst_rd_tb.sv
module sbm_burst_rd_tb;

  localparam int ADDR_W = 26;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 4;
  localparam int LAT_W  = 4;
  localparam int LEN_W  = 4;
  localparam int TURN_W = 4;
  localparam int WD_LIMIT = 190000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  cfg_div_m1 = '0;
  logic [LAT_W-1:0]  cfg_lat = '0;
  logic [LEN_W-1:0]  cfg_len_m1 = '0;
  logic [TURN_W-1:0] cfg_turn = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              mem_clk;
  logic              mem_ce_n;
  logic              mem_adv_n;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_wait_n = 1'b1;
  logic [DATA_W-1:0] mem_dq = '0;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sbm_burst_rd #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
    .LAT_W(LAT_W), .LEN_W(LEN_W), .TURN_W(TURN_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_div_m1(cfg_div_m1), .cfg_lat(cfg_lat), .cfg_len_m1(cfg_len_m1), .cfg_turn(cfg_turn),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_clk(mem_clk), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_addr(mem_addr),
    .mem_wait_n(mem_wait_n), .mem_dq(mem_dq),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WD_LIMIT && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a, input int i);
    return DATA_W'(a[15:0] + 16'h03C1 * i[15:0]) ^ 16'h5A5A;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input int div, input int lat, input int len, input int turn,
                           input logic [ADDR_W-1:0] addr, input logic [31:0] wmask);
    int d_per, lowc, lat_n, nwords, n, rises, words, last_rise, adv_cnt, hi_cnt;
    int first_rise, first_cap, bad_per, bad_cap, bad_idle, bad_addr, gap;
    int exp_first, exp_total, k, w;
    bit prev, cap;
    d_per  = ((div == 0) ? 1 : div) + 1;
    lowc   = d_per - d_per / 2;
    lat_n  = lat + 2;
    nwords = len + 1;
    // Expected edge bookkeeping, from the requirements alone.
    exp_first = -1;
    k = lat_n;
    w = 0;
    while (w < nwords) begin
      if (!(k < 32 && wmask[k])) begin
        if (exp_first < 0) exp_first = k;
        w++;
      end
      k++;
    end
    exp_total = k;

    @(negedge clk);
    cfg_div_m1 = DIV_W'(div);
    cfg_lat    = LAT_W'(lat);
    cfg_len_m1 = LEN_W'(len);
    cfg_turn   = TURN_W'(turn);
    req_addr   = addr;
    req_valid  = 1'b1;
    mem_wait_n = !wmask[0];
    mem_dq     = pat(addr, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(!mem_ce_n && !mem_adv_n && !mem_clk, "R2", "start strobes {ce,adv,clk}",
          {mem_ce_n, mem_adv_n, mem_clk}, 0);

    n = 0; prev = 1'b0; rises = 0; words = 0; last_rise = 0; adv_cnt = 0; hi_cnt = 0;
    first_rise = -1; first_cap = -1; bad_per = 0; bad_cap = 0; bad_idle = 0; bad_addr = 0;
    while (!mem_ce_n && n < 4000) begin
      if (!mem_adv_n) adv_cnt++;
      if (mem_clk) hi_cnt++;
      if (mem_addr !== addr) bad_addr++;
      if (mem_clk && !prev) begin
        if (rises == 0) first_rise = n;
        else if (n - last_rise != d_per) bad_per++;
        last_rise = n;
        cap = (rises >= lat_n) && mem_wait_n && (words < nwords);
        if (rd_valid !== cap) bad_cap++;
        else if (cap && rd_data !== pat(addr, words)) bad_cap++;
        if (cap) begin
          if (first_cap < 0) first_cap = rises;
          words++;
        end
        rises++;
        mem_wait_n = (rises < 32) ? !wmask[rises] : 1'b1;
        mem_dq     = pat(addr, words);
      end else if (rd_valid) begin
        bad_idle++;
      end
      prev = mem_clk;
      @(negedge clk);
      n++;
    end
    mem_wait_n = 1'b1;

    check(bad_per == 0, "R1", "period mismatches", bad_per, 0);
    check(hi_cnt == rises * (d_per / 2), "R1", "high-phase cycles", hi_cnt, rises * (d_per / 2));
    check(adv_cnt == d_per, "R2", "strobe low cycles", adv_cnt, d_per);
    check(first_rise == lowc, "R2", "first rise cycle", first_rise, lowc);
    check(bad_addr == 0, "R2", "address changes", bad_addr, 0);
    check(first_cap == exp_first, "R3", "first data edge", first_cap, exp_first);
    check(words == nwords && bad_cap == 0, "R4", "words read / bad words", words * 1000 + bad_cap, nwords * 1000);
    check(bad_idle == 0, "R4", "valid without rise", bad_idle, 0);
    check(rises == exp_total, "R5", "total rising edges", rises, exp_total);
    check(n == exp_total * d_per && !mem_clk, "R6", "end cycle", n, exp_total * d_per);

    gap = 0;
    while (!req_ready && gap < 100) begin
      if (mem_clk || !mem_ce_n || rd_valid) bad_idle++;
      @(negedge clk);
      gap++;
    end
    check(gap == turn && bad_idle == 0, "R7", "turnaround cycles", gap, turn);
  endtask

  initial begin
    int idle_bad;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_adv_n && !mem_clk && !rd_valid, "R8", "reset state {ce,adv,clk,valid}",
          {mem_ce_n, mem_adv_n, mem_clk, rd_valid}, 4'b1100);
    check(req_ready == 1'b1, "R8", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    idle_bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (mem_clk || !mem_ce_n || !mem_adv_n || rd_valid || !req_ready) idle_bad++;
    end
    check(idle_bad == 0, "R8", "idle bus activity", idle_bad, 0);

    // Sweep every ratio field (0 included) against three latencies and two lengths.
    for (int d = 0; d < 16; d++) begin
      for (int li = 0; li < 3; li++) begin
        for (int ln = 0; ln < 2; ln++) begin
          run_burst(d, (li == 0) ? 0 : (li == 1) ? 6 : 15, ln * 2, (d + li) % 16,
                    ADDR_W'(32'h0123_4567 + d * 97 + li * 13 + ln), 32'h0);
        end
      end
    end

    // Wait patterns: latency-only waits (ignored), waits on data edges, alternating.
    for (int di = 0; di < 4; di++) begin
      for (int li = 0; li < 2; li++) begin
        for (int mi = 0; mi < 4; mi++) begin
          logic [31:0] m;
          case (mi)
            0: m = 32'h0000_0003;
            1: m = 32'h0000_000C;
            2: m = 32'hAAAA_AAAA;
            default: m = 32'h0000_0330;
          endcase
          run_burst((di == 0) ? 1 : (di == 1) ? 2 : (di == 2) ? 5 : 9, li * 3, 7, mi,
                    ADDR_W'(32'h02AB_CDE0 + di * 7 + li * 3 + mi), m);
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule